// File: doc/BRIEF.md
# Time-Match Alarm Interrupt Unit

This block watches the running time and calendar and raises an active-low interrupt when the time agrees with a programmed alarm. Six alarm fields are held in an alarm configuration vector: second, minute, hour, date, month and weekday. Each field has its own enable bit. Only the enabled fields are compared with the current BCD time. The comparison is made once per one-second tick, so a matching second causes exactly one event.

Two interrupt modes are available. In single mode the event sets a sticky alarm flag, and the interrupt line stays low for as long as the flag stays set. In pulsed mode every match sets the flag and drives the line low for a fixed window, measured as sixteen periods of a 64 Hz timebase tick, which is about 250 ms. In pulsed mode the alarm fires again on every later match.

The flag can be cleared by a user write strobe. When auto-clear is selected, it can also be cleared by a read strobe. The unit goes quiet when the alarm enable is off or when frequency-output mode is selected. While the system runs from battery, a separate enable decides whether the alarm stays active.

Top module: `alarm_irq_unit`

## Requirements
- R1: After reset, `irq_n` is 1 and `alarm_flag` is 0.
- R2: Field i (0 second, 1 minute, 2 hour, 3 date, 4 month, 5 weekday) uses `cur_time[7i+6:7i]` and `alm_cfg[8i+7:8i]`. Bit 8i+7 is the field's enable and bits 8i+6:8i hold the alarm value. A match requires equality on every enabled field. A disabled field is ignored whatever its value.
- R3: When no field is enabled, no match occurs, even if every value is equal.
- R4: The comparison only takes effect in a cycle where `sec_tick` is 1. Matching fields without a tick cause no event.
- R5: In single mode (`pulse_mode`=0), an event sets `alarm_flag` one cycle later, and `irq_n` stays 0 until the flag is cleared.
- R6: In pulsed mode (`pulse_mode`=1), an event sets `alarm_flag` and drives `irq_n` to 0. The line returns to 1 after exactly 16 `tick_64hz` pulses. An event during the window restarts the count at 16.
- R7: A `flag_clr` strobe clears `alarm_flag` in the next cycle. An event in the same cycle wins, and the flag is set.
- R8: With `auto_clr`=1, a `flag_rd` strobe clears the flag in the next cycle. With `auto_clr`=0, `flag_rd` has no effect.
- R9: While `fout_en`=1, no event occurs and `irq_n` is 1.
- R10: While `on_battery`=1 and `bat_alarm_en`=0, no event occurs and `irq_n` is 1. With `bat_alarm_en`=1, alarms work while `on_battery`=1.
- R11: While `alarm_en`=0, no event occurs and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse each second, time fields valid |
| tick_64hz | input | 1 | One-cycle pulse at 64 Hz |
| cur_time | input | 42 | Six BCD time fields, 7 bits each |
| alm_cfg | input | 48 | Six alarm fields, enable in bit 7 of each byte |
| alarm_en | input | 1 | Alarm master enable |
| pulse_mode | input | 1 | 0 single latched, 1 recurring pulse |
| auto_clr | input | 1 | Clear flag on read |
| fout_en | input | 1 | Frequency-output mode selected, alarm off |
| on_battery | input | 1 | System runs from backup supply |
| bat_alarm_en | input | 1 | Keep alarm active on battery |
| flag_clr | input | 1 | User write strobe clearing the flag |
| flag_rd | input | 1 | Status read strobe |
| irq_n | output | 1 | Active-low interrupt |
| alarm_flag | output | 1 | Sticky alarm status |

## Verification
Some properties are checked on every cycle:
- the interrupt is held released while frequency-output mode, battery gating or the master enable is off;
- the line is held low while a single-mode flag is set or a pulse window runs;
- the flag rises only after an active second tick;
- the clear strobes work as specified.

The bench scenarios cover what a per-cycle property cannot:
- the exact field-by-field match decisions;
- the pulse width of exactly sixteen 64 Hz ticks, and its restart on a second event;
- the absence of repeat events without a tick.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int NF_DEF = 6;
  localparam int FW_DEF = 7;
  localparam int PT_DEF = 16;

  typedef enum logic [2:0] {
    FLD_SEC   = 3'd0,
    FLD_MIN   = 3'd1,
    FLD_HOUR  = 3'd2,
    FLD_DATE  = 3'd3,
    FLD_MONTH = 3'd4,
    FLD_WDAY  = 3'd5
  } alarm_field_e;
endpackage

// File: rtl/alarm_match.sv
module alarm_match #(
  parameter int NUM_FIELDS = 6,
  parameter int FIELD_W    = 7
) (
  input  logic [NUM_FIELDS*FIELD_W-1:0]     cur_time,
  input  logic [NUM_FIELDS*(FIELD_W+1)-1:0] alm_cfg,
  output logic                              match
);
  localparam int CFG_W = FIELD_W + 1;

  logic [NUM_FIELDS-1:0] fld_en;
  logic [NUM_FIELDS-1:0] fld_ok;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    logic [FIELD_W-1:0] now_val;
    logic [FIELD_W-1:0] alm_val;
    assign now_val   = cur_time[i*FIELD_W +: FIELD_W];
    assign alm_val   = alm_cfg[i*CFG_W +: FIELD_W];
    assign fld_en[i] = alm_cfg[i*CFG_W + FIELD_W];
    assign fld_ok[i] = ~fld_en[i] | (now_val == alm_val);
  end

  assign match = (&fld_ok) & (|fld_en);
endmodule

// File: rtl/alarm_pulse.sv
module alarm_pulse #(
  parameter int PULSE_TICKS = 16,
  parameter int CNT_W       = $clog2(PULSE_TICKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             tick,
  output logic             busy,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_en = 1'b1;
      cnt_d  = CNT_W'(PULSE_TICKS);
    end else if (tick && (cnt_q != '0)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign busy = (cnt_q != '0);
  assign cnt  = cnt_q;
endmodule

// File: rtl/alarm_status.sv
module alarm_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  logic flag_q;
  logic flag_d;
  logic flag_en;

  always_comb begin
    flag_en = set | clr;
    flag_d  = set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/alarm_irq_unit.sv
module alarm_irq_unit
  import alarm_pkg::*;
#(
  parameter int NUM_FIELDS  = NF_DEF,
  parameter int FIELD_W     = FW_DEF,
  parameter int PULSE_TICKS = PT_DEF
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              sec_tick,
  input  logic                              tick_64hz,
  input  logic [NUM_FIELDS*FIELD_W-1:0]     cur_time,
  input  logic [NUM_FIELDS*(FIELD_W+1)-1:0] alm_cfg,
  input  logic                              alarm_en,
  input  logic                              pulse_mode,
  input  logic                              auto_clr,
  input  logic                              fout_en,
  input  logic                              on_battery,
  input  logic                              bat_alarm_en,
  input  logic                              flag_clr,
  input  logic                              flag_rd,
  output logic                              irq_n,
  output logic                              alarm_flag
);
  localparam int CNT_W = $clog2(PULSE_TICKS + 1);

  logic [1:0]       rst_pipe_q;
  logic             rst_n_s;
  logic             time_match;
  logic             alarm_active;
  logic             fire;
  logic             flag_clear;
  logic             pulse_busy;
  logic [CNT_W-1:0] pulse_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_n_s = rst_pipe_q[1];

  alarm_match #(
    .NUM_FIELDS(NUM_FIELDS),
    .FIELD_W   (FIELD_W)
  ) u_match (
    .cur_time(cur_time),
    .alm_cfg (alm_cfg),
    .match   (time_match)
  );

  always_comb begin
    alarm_active = alarm_en & ~fout_en & (~on_battery | bat_alarm_en);
    fire         = sec_tick & alarm_active & time_match;
    flag_clear   = flag_clr | (auto_clr & flag_rd);
  end

  alarm_status u_status (
    .clk  (clk),
    .rst_n(rst_n_s),
    .set  (fire),
    .clr  (flag_clear),
    .flag (alarm_flag)
  );

  alarm_pulse #(
    .PULSE_TICKS(PULSE_TICKS),
    .CNT_W      (CNT_W)
  ) u_pulse (
    .clk  (clk),
    .rst_n(rst_n_s),
    .load (fire & pulse_mode),
    .tick (tick_64hz),
    .busy (pulse_busy),
    .cnt  (pulse_cnt)
  );

  assign irq_n = ~(alarm_active & ((~pulse_mode & alarm_flag) | pulse_busy));
endmodule

// File: rtl/alarm_irq_unit_chk.sv
module alarm_irq_unit_chk #(
  parameter int NUM_FIELDS  = 6,
  parameter int FIELD_W     = 7,
  parameter int PULSE_TICKS = 16,
  parameter int CNT_W       = 5
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              sec_tick,
  input logic [NUM_FIELDS*(FIELD_W+1)-1:0] alm_cfg,
  input logic                              alarm_en,
  input logic                              pulse_mode,
  input logic                              auto_clr,
  input logic                              fout_en,
  input logic                              on_battery,
  input logic                              bat_alarm_en,
  input logic                              flag_clr,
  input logic                              flag_rd,
  input logic                              irq_n,
  input logic                              alarm_flag,
  input logic [CNT_W-1:0]                  pulse_cnt
);
  logic any_en;
  logic act;

  always_comb begin
    any_en = 1'b0;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      any_en = any_en | alm_cfg[i*(FIELD_W+1) + FIELD_W];
    end
    act = alarm_en & ~fout_en & (~on_battery | bat_alarm_en);
  end

  p_no_field_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick && !any_en && !alarm_flag |=> !alarm_flag);

  p_set_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> $past(sec_tick && act));

  p_single_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse_mode && alarm_flag && act |-> !irq_n);

  p_pulse_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_cnt <= CNT_W'(PULSE_TICKS));

  p_pulse_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_cnt != '0) && act |-> !irq_n);

  p_user_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr && !sec_tick |=> !alarm_flag);

  p_auto_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_rd && auto_clr && !sec_tick |=> !alarm_flag);

  p_fout_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fout_en |-> irq_n);

  p_bat_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    on_battery && !bat_alarm_en |-> irq_n);

  p_disabled_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !alarm_en |-> irq_n);
endmodule

bind alarm_irq_unit alarm_irq_unit_chk #(
  .NUM_FIELDS (NUM_FIELDS),
  .FIELD_W    (FIELD_W),
  .PULSE_TICKS(PULSE_TICKS),
  .CNT_W      (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n_s),
  .sec_tick    (sec_tick),
  .alm_cfg     (alm_cfg),
  .alarm_en    (alarm_en),
  .pulse_mode  (pulse_mode),
  .auto_clr    (auto_clr),
  .fout_en     (fout_en),
  .on_battery  (on_battery),
  .bat_alarm_en(bat_alarm_en),
  .flag_clr    (flag_clr),
  .flag_rd     (flag_rd),
  .irq_n       (irq_n),
  .alarm_flag  (alarm_flag),
  .pulse_cnt   (pulse_cnt)
);

// File: tb/alarm_irq_unit_test.sv
module alarm_irq_unit_test;
  localparam logic [41:0] TM = {7'h03, 7'h12, 7'h31, 7'h23, 7'h59, 7'h45};
  localparam int NV = 9;
  // {alarm config, time, expected match}
  localparam logic [90:0] VEC [NV] = '{
    {8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hC5, TM, 1'b1},  // R2 second only
    {8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hC4, TM, 1'b0},  // R2 second differs
    {8'h03, 8'h12, 8'h31, 8'h23, 8'h59, 8'h45, TM, 1'b0},  // R3 none enabled
    {8'h83, 8'h92, 8'hB1, 8'hA3, 8'hD9, 8'hC5, TM, 1'b1},  // R2 all fields
    {8'h83, 8'h91, 8'hB1, 8'hA3, 8'hD9, 8'hC5, TM, 1'b0},  // R2 month differs
    {8'h00, 8'h00, 8'h00, 8'hA3, 8'hD9, 8'h00, TM, 1'b1},  // R2 hour+minute
    {8'h83, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, TM, 1'b1},  // R2 weekday
    {8'h84, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, TM, 1'b0},  // R2 weekday differs
    {8'h00, 8'h00, 8'hB1, 8'h00, 8'h00, 8'h12, TM, 1'b1}   // R2 disabled field ignored
  };

  logic        clk;
  logic        rst_n;
  logic        sec_tick, tick_64hz;
  logic [41:0] cur_time;
  logic [47:0] alm_cfg;
  logic        alarm_en, pulse_mode, auto_clr, fout_en, on_battery, bat_alarm_en;
  logic        flag_clr, flag_rd;
  logic        irq_n, alarm_flag;
  int          n_chk = 0;
  int          n_bad = 0;
  logic        done = 1'b0;

  alarm_irq_unit uut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .tick_64hz(tick_64hz),
    .cur_time(cur_time), .alm_cfg(alm_cfg), .alarm_en(alarm_en),
    .pulse_mode(pulse_mode), .auto_clr(auto_clr), .fout_en(fout_en),
    .on_battery(on_battery), .bat_alarm_en(bat_alarm_en),
    .flag_clr(flag_clr), .flag_rd(flag_rd), .irq_n(irq_n),
    .alarm_flag(alarm_flag)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic sec_pulse();
    @(negedge clk) sec_tick = 1'b1;
    @(negedge clk) sec_tick = 1'b0;
  endtask

  task automatic t64_pulse();
    @(negedge clk) tick_64hz = 1'b1;
    @(negedge clk) tick_64hz = 1'b0;
  endtask

  task automatic user_clr();
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
  endtask

  task automatic status_rd();
    @(negedge clk) flag_rd = 1'b1;
    @(negedge clk) flag_rd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sec_tick = 1'b0; tick_64hz = 1'b0;
    cur_time = TM; alm_cfg = '0;
    alarm_en = 1'b1; pulse_mode = 1'b0; auto_clr = 1'b0; fout_en = 1'b0;
    on_battery = 1'b0; bat_alarm_en = 1'b0; flag_clr = 1'b0; flag_rd = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 irq_n", irq_n, 1'b1);
    check("R1 flag", alarm_flag, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 irq_n after release", irq_n, 1'b1);
    check("R1 flag after release", alarm_flag, 1'b0);

    // table walk, single mode
    for (int i = 0; i < NV; i++) begin
      user_clr();
      @(negedge clk);
      alm_cfg  = VEC[i][90:43];
      cur_time = VEC[i][42:1];
      sec_pulse();
      check($sformatf("R2/R3 vec %0d flag", i), alarm_flag, VEC[i][0]);
      check($sformatf("R5 vec %0d irq_n", i), irq_n, ~VEC[i][0]);
    end

    // R4: no tick, no event
    user_clr();
    alm_cfg = {40'h0, 8'hC5};
    cur_time = TM;
    repeat (10) @(negedge clk);
    check("R4 no tick flag", alarm_flag, 1'b0);
    sec_pulse();
    check("R4 tick flag", alarm_flag, 1'b1);

    // R5: single mode holds until clear
    repeat (20) @(negedge clk);
    check("R5 irq held", irq_n, 1'b0);
    user_clr();
    check("R5 released on clear", irq_n, 1'b1);
    check("R7 flag cleared", alarm_flag, 1'b0);

    // R7: event wins over clear in same cycle
    @(negedge clk) begin sec_tick = 1'b1; flag_clr = 1'b1; end
    @(negedge clk) begin sec_tick = 1'b0; flag_clr = 1'b0; end
    check("R7 set wins", alarm_flag, 1'b1);

    // R8: read without auto clear keeps flag, with auto clear clears
    status_rd();
    check("R8 read no auto", alarm_flag, 1'b1);
    auto_clr = 1'b1;
    status_rd();
    check("R8 read auto clear", alarm_flag, 1'b0);
    auto_clr = 1'b0;

    // R6: pulsed mode window
    pulse_mode = 1'b1;
    sec_pulse();
    check("R6 flag", alarm_flag, 1'b1);
    check("R6 irq low", irq_n, 1'b0);
    for (int k = 0; k < 15; k++) t64_pulse();
    check("R6 low after 15 ticks", irq_n, 1'b0);
    t64_pulse();
    check("R6 high after 16 ticks", irq_n, 1'b1);
    check("R6 flag stays", alarm_flag, 1'b1);
    repeat (20) @(negedge clk);
    check("R4 no repeat without tick", irq_n, 1'b1);
    // retrigger
    sec_pulse();
    for (int k = 0; k < 10; k++) t64_pulse();
    sec_pulse();
    for (int k = 0; k < 15; k++) t64_pulse();
    check("R6 retrigger still low", irq_n, 1'b0);
    t64_pulse();
    check("R6 retrigger released", irq_n, 1'b1);
    pulse_mode = 1'b0;

    // R9: frequency-output mode
    user_clr();
    sec_pulse();
    check("R9 pre flag", alarm_flag, 1'b1);
    @(negedge clk) fout_en = 1'b1;
    @(negedge clk);
    check("R9 irq released", irq_n, 1'b1);
    user_clr();
    sec_pulse();
    check("R9 no event", alarm_flag, 1'b0);
    fout_en = 1'b0;

    // R10: battery gating
    on_battery = 1'b1;
    sec_pulse();
    check("R10 battery blocked", alarm_flag, 1'b0);
    check("R10 irq quiet", irq_n, 1'b1);
    bat_alarm_en = 1'b1;
    sec_pulse();
    check("R10 battery allowed", alarm_flag, 1'b1);
    check("R10 irq low", irq_n, 1'b0);
    on_battery = 1'b0; bat_alarm_en = 1'b0;

    // R11: master enable off
    user_clr();
    alarm_en = 1'b0;
    sec_pulse();
    check("R11 no event", alarm_flag, 1'b0);
    check("R11 irq quiet", irq_n, 1'b1);
    alarm_en = 1'b1;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule